// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block is the host side of a parallel-port link that has already negotiated ECP mode. When a read request arrives it sets the link up for ECP if that has not been done yet. It then turns the bus around so that the peripheral drives the data lines. After that it takes bytes from the peripheral using the nAck/nAutoFd handshake. A byte sent with Busy high is data. A byte sent with Busy low is a command. A command with its top bit clear is a repeat count, and the data byte that follows it is expanded into that many extra copies. A command with its top bit set selects a channel, and the block drops it.

The expanded bytes leave on a valid/ready stream. A request asks for a fixed number of bytes, given on `req_len_i` when `start_i` pulses. When the request ends, `done_o` pulses for one cycle and `count_o` gives the number of bytes delivered. If the request ended on a handshake timeout, `err_o` is high in that same cycle. The block counts its timeouts in units of `tick_i`. Once the bus is in reverse, it stays in reverse across requests. `dir_in_o` stays high for that whole time, so external logic can turn off the host's data drivers.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, `n_autofd_o`, `n_strobe_o`, `n_init_o` and `n_selin_o` are high, and `dir_in_o`, `out_valid_o` and `done_o` are low.
- R2: The first request starts ECP setup. The block drives `n_autofd_o` low and waits for `perror_i` high. It then sets `dir_in_o`, waits one setup tick, and drives `n_init_o` low while `n_strobe_o` and `n_selin_o` stay high. It then waits for `perror_i` low. From then on, `dir_in_o` stays high and `n_strobe_o` and `n_selin_o` stay high.
- R3: A byte taken while `n_ack_i` is low and `busy_i` is high is a data byte. It appears once on `out_data_o` with its bus value, and `out_valid_o` and the data hold until `out_ready_i` is high.
- R4: A command byte (`busy_i` low) with bit 7 set produces no output byte.
- R5: A command byte with bit 7 clear and count N in bits 6:0 makes the next data byte appear N+1 times in a row. No later bus byte is taken until all the copies have been sent.
- R6: While `out_ready_i` stays high, the stored repeats leave at one byte per clock.
- R7: After each bus byte is taken, `n_autofd_o` goes high. Once `n_ack_i` returns high, `n_autofd_o` goes low again.
- R8: When a request's count runs out partway through a run, the rest of the run is kept. It is sent at the start of the next request, before any new bus byte.
- R9: If `n_ack_i` stays high for the idle limit (IDLE_TICKS ticks) while bytes are still owed, the request ends with `done_o`, `err_o` low, and `count_o` equal to the bytes delivered so far.
- R10: If `n_ack_i` does not return high within RESP_TICKS ticks after an acknowledge, the request ends with `done_o` and `err_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base pulse for the protocol timeouts |
| start_i | input | 1 | Starts a request when the block is idle |
| req_len_i | input | LEN_W | Number of bytes requested |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Consumer accepts the byte |
| out_data_o | output | DW | Output byte |
| done_o | output | 1 | One-cycle pulse when a request ends |
| err_o | output | 1 | Request ended on a handshake timeout (valid with done_o) |
| count_o | output | LEN_W | Bytes delivered by the last request |
| n_autofd_o | output | 1 | Host nAutoFd line |
| n_strobe_o | output | 1 | Host nStrobe line |
| n_init_o | output | 1 | Host nInit line |
| n_selin_o | output | 1 | Host nSelectIn line |
| dir_in_o | output | 1 | High while the data bus is an input (reverse mode) |
| n_ack_i | input | 1 | Peripheral nAck line |
| busy_i | input | 1 | Peripheral Busy line (high = data byte) |
| perror_i | input | 1 | Peripheral PError line |
| bus_data_i | input | DW | Parallel data bus |

## Verification
A bad run count or a stuck repeat flag shows on the stream at the next expanded byte. The byte appears the wrong number of times, or a fresh bus byte arrives before the run is complete. The reference queue flags this in the same cycle as the handshake. A residue that a split request loses or duplicates shows as the first byte of the following request. A broken direction or handshake state shows on the host control lines within a cycle or two of the bus event that should have moved them. The peripheral model then stalls, and the request-end checks report it.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_TURN_A,
      ST_TURN_B,
      ST_NEXT,
      ST_REPEAT,
      ST_WAIT,
      ST_DATA,
      ST_ACK,
      ST_DONE
   } rx_state_t;

   typedef struct packed {
      logic autofd_n;
      logic strobe_n;
      logic init_n;
      logic selin_n;
      logic dir_in;
   } host_pins_t;

   localparam host_pins_t PINS_IDLE = '{autofd_n: 1'b1, strobe_n: 1'b1,
                                        init_n: 1'b1, selin_n: 1'b1, dir_in: 1'b0};

endpackage

// File: rtl/ecp_tick_timer.sv
module ecp_tick_timer #(
   parameter int MAX_TICKS = 2000,
   localparam int W = $clog2(MAX_TICKS + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);

   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_inc;

   assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
   assign expired_o = tick_i && (cnt_inc >= {1'b0, limit_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (tick_i && !expired_o)
         cnt_q <= cnt_inc[W-1:0];
   end

endmodule

// File: rtl/ecp_run_store.sv
module ecp_run_store #(
   parameter int DW = 8,
   localparam int RW = DW - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [RW-1:0] load_val_i,
   input  logic          cap_i,
   input  logic [DW-1:0] cap_val_i,
   input  logic          dec_i,
   output logic [RW-1:0] run_o,
   output logic          armed_o,
   output logic [DW-1:0] rep_byte_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o      <= '0;
         armed_o    <= 1'b0;
         rep_byte_o <= '0;
      end else begin
         if (load_i) begin
            run_o   <= load_val_i;
            armed_o <= 1'b1;
         end else begin
            if (cap_i && armed_o) begin
               rep_byte_o <= cap_val_i;
               armed_o    <= 1'b0;
            end
            if (dec_i && run_o != '0)
               run_o <= run_o - 1'b1;
         end
      end
   end

endmodule

// File: rtl/ecp_pin_drive.sv
module ecp_pin_drive
   import ecp_rx_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  host_pins_t pins_i,
   output host_pins_t pins_o
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pins_o <= PINS_IDLE;
            else
               pins_o <= pins_i;
         end
      end else begin : g_comb
         assign pins_o = pins_i;
      end
   endgenerate

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
   import ecp_rx_pkg::*;
#(
   parameter int DW          = 8,
   parameter int LEN_W       = 16,
   parameter int SETUP_TICKS = 1,
   parameter int RESP_TICKS  = 6,
   parameter int IDLE_TICKS  = 2000,
   parameter bit REG_PINS    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic [LEN_W-1:0] req_len_i,
   output logic             out_valid_o,
   input  logic             out_ready_i,
   output logic [DW-1:0]    out_data_o,
   output logic             done_o,
   output logic             err_o,
   output logic [LEN_W-1:0] count_o,
   output logic             n_autofd_o,
   output logic             n_strobe_o,
   output logic             n_init_o,
   output logic             n_selin_o,
   output logic             dir_in_o,
   input  logic             n_ack_i,
   input  logic             busy_i,
   input  logic             perror_i,
   input  logic [DW-1:0]    bus_data_i
);

   localparam int MAXT = IDLE_TICKS;
   localparam int TW   = $clog2(MAXT + 1);
   localparam int RW   = DW - 1;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
      if (SETUP_TICKS < 1 || RESP_TICKS < 1) begin : g_bad_resp
         $error("tick limits must be positive");
      end
      if (IDLE_TICKS < RESP_TICKS || IDLE_TICKS < SETUP_TICKS) begin : g_bad_idle
         $error("IDLE_TICKS must be the largest limit");
      end
   endgenerate

   rx_state_t        st_q, st_d;
   logic [LEN_W-1:0] rem_q, cnt_q;
   logic             ecp_q, rev_q, init_lo_q;
   logic [DW-1:0]    bus_q;
   logic             done_q, err_q;

   logic             expired;
   logic [TW-1:0]    limit;
   logic             fail;
   logic             emit;
   logic             cmd_load;
   logic [RW-1:0]    run_cnt;
   logic             armed;
   logic [DW-1:0]    rep_byte;
   host_pins_t       pins_d, pins_q;

   always_comb begin
      unique case (st_q)
         ST_TURN_A: limit = TW'(SETUP_TICKS);
         ST_WAIT:   limit = TW'(IDLE_TICKS);
         default:   limit = TW'(RESP_TICKS);
      endcase
   end

   ecp_tick_timer #(.MAX_TICKS(MAXT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (st_d != st_q),
      .tick_i   (tick_i),
      .limit_i  (limit),
      .expired_o(expired)
   );

   assign out_valid_o = (st_q == ST_REPEAT) || (st_q == ST_DATA);
   assign out_data_o  = (st_q == ST_REPEAT) ? rep_byte : bus_q;
   assign emit        = out_valid_o && out_ready_i;
   assign cmd_load    = (st_q == ST_WAIT) && !n_ack_i && !busy_i && !bus_data_i[DW-1];

   ecp_run_store #(.DW(DW)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (cmd_load),
      .load_val_i(bus_data_i[RW-1:0]),
      .cap_i     ((st_q == ST_DATA) && out_ready_i),
      .cap_val_i (bus_q),
      .dec_i     ((st_q == ST_REPEAT) && out_ready_i),
      .run_o     (run_cnt),
      .armed_o   (armed),
      .rep_byte_o(rep_byte)
   );

   always_comb begin
      st_d = st_q;
      fail = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (req_len_i == '0)  st_d = ST_DONE;
               else if (rev_q)       st_d = ST_NEXT;
               else if (ecp_q)       st_d = ST_TURN_A;
               else                  st_d = ST_SETUP;
            end
         end
         ST_SETUP: begin
            if (perror_i)      st_d = ST_TURN_A;
            else if (expired) begin st_d = ST_DONE; fail = 1'b1; end
         end
         ST_TURN_A: begin
            if (expired) st_d = ST_TURN_B;
         end
         ST_TURN_B: begin
            if (!perror_i)     st_d = ST_NEXT;
            else if (expired) begin st_d = ST_DONE; fail = 1'b1; end
         end
         ST_NEXT: begin
            if (rem_q == '0)                      st_d = ST_DONE;
            else if (run_cnt != '0 && !armed)     st_d = ST_REPEAT;
            else                                  st_d = ST_WAIT;
         end
         ST_REPEAT: begin
            if (out_ready_i && (run_cnt == RW'(1) || rem_q == LEN_W'(1)))
               st_d = ST_NEXT;
         end
         ST_WAIT: begin
            if (!n_ack_i)      st_d = busy_i ? ST_DATA : ST_ACK;
            else if (expired)  st_d = ST_DONE;
         end
         ST_DATA: begin
            if (out_ready_i) st_d = ST_ACK;
         end
         ST_ACK: begin
            if (n_ack_i)       st_d = ST_NEXT;
            else if (expired) begin st_d = ST_DONE; fail = 1'b1; end
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         rem_q     <= '0;
         cnt_q     <= '0;
         ecp_q     <= 1'b0;
         rev_q     <= 1'b0;
         init_lo_q <= 1'b0;
         bus_q     <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_d == ST_DONE);
         if (st_q == ST_IDLE && start_i) begin
            rem_q <= req_len_i;
            cnt_q <= '0;
            err_q <= 1'b0;
         end else if (emit) begin
            rem_q <= rem_q - 1'b1;
            cnt_q <= cnt_q + 1'b1;
         end
         if (fail)
            err_q <= 1'b1;
         if (st_d == ST_SETUP)
            ecp_q <= 1'b1;
         else if (st_q == ST_SETUP && fail)
            ecp_q <= 1'b0;
         if (st_d == ST_TURN_A)
            rev_q <= 1'b1;
         if (st_q == ST_TURN_A && st_d == ST_TURN_B)
            init_lo_q <= 1'b1;
         if (st_q == ST_WAIT && !n_ack_i)
            bus_q <= bus_data_i;
      end
   end

   always_comb begin
      pins_d          = PINS_IDLE;
      pins_d.autofd_n = !ecp_q || (st_q == ST_ACK);
      pins_d.init_n   = !init_lo_q;
      pins_d.dir_in   = rev_q;
   end

   ecp_pin_drive #(.REG_OUT(REG_PINS)) u_pins (
      .clk   (clk),
      .rst_n (rst_n),
      .pins_i(pins_d),
      .pins_o(pins_q)
   );

   assign n_autofd_o = pins_q.autofd_n;
   assign n_strobe_o = pins_q.strobe_n;
   assign n_init_o   = pins_q.init_n;
   assign n_selin_o  = pins_q.selin_n;
   assign dir_in_o   = pins_q.dir_in;
   assign done_o     = done_q;
   assign err_o      = done_q && err_q;
   assign count_o    = cnt_q;

endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_valid_o,
   input logic          out_ready_i,
   input logic [DW-1:0] out_data_o,
   input logic          done_o,
   input logic          n_autofd_o,
   input logic          n_strobe_o,
   input logic          n_selin_o,
   input logic          dir_in_o,
   input logic          n_ack_i
);

   assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(dir_in_o));

   assert_rev_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dir_in_o |-> (n_strobe_o && n_selin_o));

   assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

   assert_out_reverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> dir_in_o);

   assert_ack_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(n_autofd_o) && dir_in_o) |-> !$past(n_ack_i));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid_o(out_valid_o),
   .out_ready_i(out_ready_i),
   .out_data_o (out_data_o),
   .done_o     (done_o),
   .n_autofd_o (n_autofd_o),
   .n_strobe_o (n_strobe_o),
   .n_selin_o  (n_selin_o),
   .dir_in_o   (dir_in_o),
   .n_ack_i    (n_ack_i)
);

// File: tb/test_ecp_rev_rx.sv
module test_ecp_rev_rx;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        start = 1'b0;
   logic [15:0] req_len = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;
   logic        done;
   logic        err;
   logic [15:0] count;
   logic        n_autofd, n_strobe, n_init, n_selin, dir_in;
   logic        n_ack = 1'b1;
   logic        busy = 1'b0;
   logic        perror = 1'b0;
   logic [7:0]  bus = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [7:0] exp_q[$];
   int hs_cyc[$];
   int m_armed = 0;
   int m_run = 0;
   bit got_done = 0;
   int got_cnt = 0;
   bit got_err = 0;
   bit hold_pend = 0;
   logic [7:0] hold_val = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecp_rev_rx i_ecp_rev_rx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .req_len_i(req_len),
      .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
      .done_o(done), .err_o(err), .count_o(count),
      .n_autofd_o(n_autofd), .n_strobe_o(n_strobe), .n_init_o(n_init),
      .n_selin_o(n_selin), .dir_in_o(dir_in),
      .n_ack_i(n_ack), .busy_i(busy), .perror_i(perror), .bus_data_i(bus)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-clock comparison of the stream against the reference queue
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (hold_pend) begin
            chk(out_valid && out_data == hold_val, "R3 byte held while not ready",
                int'(out_data), int'(hold_val));
         end
         hold_pend = out_valid && !out_ready;
         hold_val  = out_data;
         if (out_valid && out_ready) begin
            hs_cyc.push_back(cyc);
            if (exp_q.size() == 0)
               chk(0, "R4/R5 unexpected output byte", int'(out_data), -1);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(out_data == e, "R3/R5 output byte", int'(out_data), int'(e));
            end
         end
         if (done) begin
            got_done = 1;
            got_cnt  = int'(count);
            got_err  = err;
         end
      end
   end

   task automatic model_byte(input logic b, input logic [7:0] d);
      if (b) begin
         exp_q.push_back(d);
         if (m_armed != 0) begin
            for (int i = 0; i < m_run; i++) exp_q.push_back(d);
            m_armed = 0;
         end
      end else if (!d[7]) begin
         m_armed = 1;
         m_run = int'(d[6:0]);
      end
   endtask

   task automatic send(input logic b, input logic [7:0] d);
      bit ok;
      model_byte(b, d);
      @(negedge clk); busy = b; bus = d;
      @(negedge clk); n_ack = 1'b0;
      while (n_autofd !== 1'b1) @(negedge clk);
      @(negedge clk); n_ack = 1'b1;
      ok = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (n_autofd === 1'b0) begin ok = 1; break; end
      end
      chk(ok, "R7 nAutoFd low after nAck high", int'(n_autofd), 0);
   endtask

   task automatic periph_enter();
      while (n_autofd !== 1'b0) @(negedge clk);
      chk(dir_in == 1'b0, "R2 setup before turnaround", int'(dir_in), 0);
      @(negedge clk); perror = 1'b1;
      while (n_init !== 1'b0) @(negedge clk);
      chk(dir_in && n_strobe && n_selin, "R2 turnaround lines",
          int'({dir_in, n_strobe, n_selin}), 7);
      @(negedge clk); perror = 1'b0;
   endtask

   task automatic request(input int len);
      got_done = 0;
      @(negedge clk); start = 1'b1; req_len = 16'(len);
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 5000 && !got_done; i++) @(negedge clk);
      chk(got_done, "R9 request completes", int'(got_done), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk({n_autofd, n_strobe, n_init, n_selin} == 4'hF && !dir_in && !out_valid && !done,
          "R1 reset state", int'({n_autofd, n_strobe, n_init, n_selin, dir_in}), 30);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // A: ECP entry, channel address dropped, run split across requests
      fork
         request(4);
         begin
            periph_enter();
            send(1'b1, 8'h11);
            send(1'b0, 8'h85);
            send(1'b1, 8'h22);
            send(1'b0, 8'h02);
            send(1'b1, 8'h5A);
         end
      join
      chk(got_cnt == 4 && !got_err, "R4 count with channel byte dropped", got_cnt, 4);
      chk(dir_in == 1'b1, "R2 reverse held after request", int'(dir_in), 1);

      // B: residue first, then new run of 4 extra, request 3
      fork
         request(3);
         begin
            send(1'b0, 8'h04);
            send(1'b1, 8'h33);
         end
      join
      chk(got_cnt == 3 && !got_err, "R8 residue then new bytes", got_cnt, 3);

      // C: residue only, one byte per clock
      hs_cyc.delete();
      request(3);
      chk(got_cnt == 3, "R8 residue count", got_cnt, 3);
      chk(hs_cyc.size() == 3 && hs_cyc[2] - hs_cyc[0] == 2, "R6 repeats back to back",
          hs_cyc.size() == 3 ? hs_cyc[2] - hs_cyc[0] : -1, 2);

      // D: output stalls
      fork
         request(2);
         begin
            send(1'b1, 8'h44);
            send(1'b1, 8'h66);
         end
         begin
            for (int i = 0; i < 60 && !got_done; i++) begin
               @(negedge clk); out_ready = (i % 4) == 3;
            end
            out_ready = 1'b1;
         end
      join
      out_ready = 1'b1;
      chk(got_cnt == 2 && !got_err, "R3 stalled stream count", got_cnt, 2);

      // E: idle timeout ends quietly
      fork
         request(3);
         send(1'b1, 8'h77);
      join
      chk(got_cnt == 1 && !got_err, "R9 idle timeout partial count", got_cnt, 1);

      // F: acknowledge timeout
      model_byte(1'b1, 8'h88);
      fork
         request(1);
         begin
            @(negedge clk); busy = 1'b1; bus = 8'h88;
            @(negedge clk); n_ack = 1'b0;
         end
      join
      chk(got_done && got_err, "R10 ack timeout error", int'(got_err), 1);
      chk(got_cnt == 1, "R10 delivered before timeout", got_cnt, 1);
      n_ack = 1'b1;
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all expected bytes seen", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule